// File: doc/BRIEF.md
# Exception Entry and Vector Unit

This unit moves a processor into exception mode when it is asked to. A one-cycle request carries an exception kind, the program counter of the faulting instruction and a flag that says whether that instruction sits in a branch delay slot. The current exception-level and boot-vector status bits come from the status register owner. On the clock edge that ends the request cycle, the unit commits several values:

- the exception return address and the branch-delay flag;
- a 32-bit cause word holding the encoded cause code;
- the faulting address, for address-related kinds;
- the target program counter of the handler;
- the new exception-level bit.

If the processor was already at exception level, the return address and the delay flag are frozen. Nested exceptions always go to the common vector. Several kinds share one cause code, and only the vector offset tells them apart. The vector base follows the boot-vector bit.

The exception-level output is a registered copy of the incoming bit, forced to 1 after an accepted request, so the status owner can write it back. After an accepted request the unit is busy for one cycle, and a request that arrives during that cycle is dropped.

Top module: `exc_entry_unit`

## Requirements
- R1: On an accepted request with `exl_i`=1, `epc_o` and `cause_o[31]` keep their previous values.
- R2: On an accepted request with `exl_i`=0:
  - if `delay_i`=1, `epc_o` becomes `pc_i`-4 (modulo 2^64) and `cause_o[31]` becomes 1;
  - otherwise `epc_o` becomes `pc_i` and `cause_o[31]` becomes 0.
- R3: The vector offset is chosen as follows:
  - 0x180 when `exl_i`=1, for any kind;
  - otherwise 0x080 for kinds 14 and 15 (refill, load and store);
  - otherwise 0x280 for kind 13 (coprocessor-2 trap);
  - otherwise 0x180.
- R4: `next_pc_o` becomes base plus the sign-extended offset. The base is 0xFFFFFFFFBFC00200 when `bev_i`=1 and 0xFFFFFFFF80000000 when `bev_i`=0.
- R5: `kind_i` maps to a cause code as listed below. Kinds 14 and 16 give code 2, and kinds 15 and 17 give code 3.

| `kind_i` | Meaning | Cause code |
|---|---|---|
| 0 | interrupt | 0x00 |
| 1 | TLB modify | 0x01 |
| 2 | TLB load | 0x02 |
| 3 | TLB store | 0x03 |
| 4 | address error, load | 0x04 |
| 5 | address error, store | 0x05 |
| 6 | syscall | 0x08 |
| 7 | breakpoint | 0x09 |
| 8 | reserved instruction | 0x0A |
| 9 | coprocessor unusable | 0x0B |
| 10 | overflow | 0x0C |
| 11 | trap | 0x0D |
| 12 | coprocessor-2 exception | 0x12 |
| 13 | coprocessor-2 trap | 0x12 |
| 14 | refill, load | 0x02 |
| 15 | refill, store | 0x03 |
| 16 | invalid, load | 0x02 |
| 17 | invalid, store | 0x03 |
| 18 | machine check | 0x18 |

- R6: The cause word holds the code in bits 6..2 and the delay flag in bit 31. All other bits read 0.
- R7: `exl_o` is 1 after an accepted request. After any other cycle it equals the `exl_i` of that cycle.
- R8: An accepted request of kind 1 to 5 or 14 to 17 loads `bad_addr_i` into `badva_o`. Any other request leaves `badva_o` unchanged.
- R9: A request in the cycle right after an accepted one is ignored: `epc_o`, `cause_o`, `badva_o` and `next_pc_o` stay unchanged.
- R10: A request with `kind_i` from 19 to 31 is ignored in the same way.
- R11: While reset is held, every output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| req_i | input | 1 | exception request, one cycle |
| kind_i | input | 5 | exception kind (R5 encoding) |
| pc_i | input | 64 | program counter of the faulting instruction |
| delay_i | input | 1 | instruction is in a branch delay slot |
| exl_i | input | 1 | current exception-level status bit |
| bev_i | input | 1 | current boot-vector status bit |
| bad_addr_i | input | 64 | faulting virtual address |
| epc_o | output | 64 | exception return address |
| cause_o | output | 32 | cause word |
| exl_o | output | 1 | updated exception-level bit |
| badva_o | output | 64 | bad virtual address |
| next_pc_o | output | 64 | handler target address |

## Verification
Every register feeds a port directly, so any wrong internal state shows up one cycle after the edge that produced it. A stuck busy flag would drop the next request, leaving `next_pc_o` and `cause_o` unchanged where new values are expected. A wrong nesting test would either move `epc_o` or fail to force the 0x180 offset. The bench therefore compares every output on every cycle against a reference computed from the requirements. It mixes random traffic, including back-to-back requests, nested requests and unknown kinds, with directed corner cases.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int XLEN   = 64;
    localparam int KIND_W = 5;
    localparam int CODE_W = 5;
    localparam int CAUSE_W = 32;

    typedef enum logic [KIND_W-1:0] {
        K_INTR      = 5'd0,
        K_TLB_MOD   = 5'd1,
        K_TLB_LD    = 5'd2,
        K_TLB_ST    = 5'd3,
        K_ADR_LD    = 5'd4,
        K_ADR_ST    = 5'd5,
        K_SYSCALL   = 5'd6,
        K_BREAK     = 5'd7,
        K_RESV      = 5'd8,
        K_CP_UNUSE  = 5'd9,
        K_OVF       = 5'd10,
        K_TRAP      = 5'd11,
        K_CP2_EXC   = 5'd12,
        K_CP2_TRAP  = 5'd13,
        K_REFILL_LD = 5'd14,
        K_REFILL_ST = 5'd15,
        K_INVAL_LD  = 5'd16,
        K_INVAL_ST  = 5'd17,
        K_MCHECK    = 5'd18
    } exc_kind_e;

    typedef struct packed {
        logic [XLEN-1:0]   epc;
        logic              bd;
        logic [CODE_W-1:0] code;
        logic              exl;
        logic [XLEN-1:0]   badva;
        logic [XLEN-1:0]   npc;
        logic              busy;
    } entry_state_t;
endpackage

// File: rtl/exc_code_map.sv
module exc_code_map
    import exc_pkg::*;
(
    input  logic [KIND_W-1:0] kind_i,
    output logic [CODE_W-1:0] code_o,
    output logic              known_o,
    output logic              addr_rel_o
);
    always_comb begin
        code_o     = '0;
        known_o    = 1'b1;
        addr_rel_o = 1'b0;
        case (kind_i)
            K_INTR:      code_o = 5'h00;
            K_TLB_MOD:   begin code_o = 5'h01; addr_rel_o = 1'b1; end
            K_TLB_LD,
            K_REFILL_LD,
            K_INVAL_LD:  begin code_o = 5'h02; addr_rel_o = 1'b1; end
            K_TLB_ST,
            K_REFILL_ST,
            K_INVAL_ST:  begin code_o = 5'h03; addr_rel_o = 1'b1; end
            K_ADR_LD:    begin code_o = 5'h04; addr_rel_o = 1'b1; end
            K_ADR_ST:    begin code_o = 5'h05; addr_rel_o = 1'b1; end
            K_SYSCALL:   code_o = 5'h08;
            K_BREAK:     code_o = 5'h09;
            K_RESV:      code_o = 5'h0A;
            K_CP_UNUSE:  code_o = 5'h0B;
            K_OVF:       code_o = 5'h0C;
            K_TRAP:      code_o = 5'h0D;
            K_CP2_EXC,
            K_CP2_TRAP:  code_o = 5'h12;
            K_MCHECK:    code_o = 5'h18;
            default:     known_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
    import exc_pkg::*;
#(
    parameter logic [XLEN-1:0] BOOT_BASE = 64'hFFFF_FFFF_BFC0_0200,
    parameter logic [XLEN-1:0] RUN_BASE  = 64'hFFFF_FFFF_8000_0000,
    parameter int              OFS_W     = 12,
    parameter logic [OFS_W-1:0] OFS_COMMON = 12'h180,
    parameter logic [OFS_W-1:0] OFS_REFILL = 12'h080,
    parameter logic [OFS_W-1:0] OFS_CPTRAP = 12'h280
) (
    input  logic [KIND_W-1:0] kind_i,
    input  logic              exl_i,
    input  logic              bev_i,
    output logic [XLEN-1:0]   target_o
);
    localparam int EXT_W = XLEN - OFS_W;

    logic [OFS_W-1:0] ofs;
    logic [XLEN-1:0]  base;

    always_comb begin
        if (exl_i)
            ofs = OFS_COMMON;
        else if (kind_i == K_REFILL_LD || kind_i == K_REFILL_ST)
            ofs = OFS_REFILL;
        else if (kind_i == K_CP2_TRAP)
            ofs = OFS_CPTRAP;
        else
            ofs = OFS_COMMON;
        base     = bev_i ? BOOT_BASE : RUN_BASE;
        target_o = base + {{EXT_W{ofs[OFS_W-1]}}, ofs};
    end
endmodule

// File: rtl/exc_epc_calc.sv
module exc_epc_calc
    import exc_pkg::*;
#(
    parameter int INSTR_BYTES = 4
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic            delay_i,
    output logic [XLEN-1:0] epc_o,
    output logic            bd_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

    always_comb begin
        bd_o  = delay_i;
        epc_o = delay_i ? (pc_i - STEP) : pc_i;
    end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_pkg::*;
#(
    parameter logic [XLEN-1:0] BOOT_BASE   = 64'hFFFF_FFFF_BFC0_0200,
    parameter logic [XLEN-1:0] RUN_BASE    = 64'hFFFF_FFFF_8000_0000,
    parameter int              INSTR_BYTES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    input  logic [KIND_W-1:0]   kind_i,
    input  logic [XLEN-1:0]     pc_i,
    input  logic                delay_i,
    input  logic                exl_i,
    input  logic                bev_i,
    input  logic [XLEN-1:0]     bad_addr_i,
    output logic [XLEN-1:0]     epc_o,
    output logic [CAUSE_W-1:0]  cause_o,
    output logic                exl_o,
    output logic [XLEN-1:0]     badva_o,
    output logic [XLEN-1:0]     next_pc_o
);
    localparam int GAP_W = CAUSE_W - 1 - CODE_W - 2;

    entry_state_t st_d, st_q;

    logic [CODE_W-1:0] code;
    logic              known;
    logic              addr_rel;
    logic [XLEN-1:0]   target;
    logic [XLEN-1:0]   epc_new;
    logic              bd_new;
    logic              accept;
    logic              busy_q;

    exc_code_map u_code (
        .kind_i     (kind_i),
        .code_o     (code),
        .known_o    (known),
        .addr_rel_o (addr_rel)
    );

    exc_vector_sel #(
        .BOOT_BASE (BOOT_BASE),
        .RUN_BASE  (RUN_BASE)
    ) u_vec (
        .kind_i   (kind_i),
        .exl_i    (exl_i),
        .bev_i    (bev_i),
        .target_o (target)
    );

    exc_epc_calc #(
        .INSTR_BYTES (INSTR_BYTES)
    ) u_epc (
        .pc_i    (pc_i),
        .delay_i (delay_i),
        .epc_o   (epc_new),
        .bd_o    (bd_new)
    );

    assign busy_q = st_q.busy;
    assign accept = req_i && known && !st_q.busy;

    always_comb begin
        st_d      = st_q;
        st_d.busy = 1'b0;
        st_d.exl  = exl_i;
        if (accept) begin
            if (!exl_i) begin
                st_d.epc = epc_new;
                st_d.bd  = bd_new;
            end
            st_d.code = code;
            st_d.exl  = 1'b1;
            st_d.npc  = target;
            if (addr_rel)
                st_d.badva = bad_addr_i;
            st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign epc_o     = st_q.epc;
    assign cause_o   = {st_q.bd, {GAP_W{1'b0}}, st_q.code, 2'b00};
    assign exl_o     = st_q.exl;
    assign badva_o   = st_q.badva;
    assign next_pc_o = st_q.npc;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_pkg::*;
#(
    parameter logic [XLEN-1:0] BOOT_BASE = 64'hFFFF_FFFF_BFC0_0200,
    parameter logic [XLEN-1:0] RUN_BASE  = 64'hFFFF_FFFF_8000_0000
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_i,
    input logic [KIND_W-1:0]   kind_i,
    input logic [XLEN-1:0]     pc_i,
    input logic                delay_i,
    input logic                exl_i,
    input logic                bev_i,
    input logic [XLEN-1:0]     epc_o,
    input logic [CAUSE_W-1:0]  cause_o,
    input logic                exl_o,
    input logic [XLEN-1:0]     badva_o,
    input logic [XLEN-1:0]     next_pc_o,
    input logic                busy_q
);
    localparam logic [XLEN-1:0] NEST_OFS = 64'h180;

    logic acc;
    assign acc = req_i && !busy_q && (kind_i <= 5'd18);

    p_epc_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc && exl_i |=> $stable(epc_o) && $stable(cause_o[31]));

    p_epc_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !exl_i && delay_i |=> (epc_o == $past(pc_i) - 64'd4) && cause_o[31]);

    p_nest_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc && exl_i |=> next_pc_o == ($past(bev_i) ? BOOT_BASE + NEST_OFS : RUN_BASE + NEST_OFS));

    p_layout_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cause_o[30:7] == '0 && cause_o[1:0] == 2'b00);

    p_exl_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> exl_o);

    p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> $stable(epc_o) && $stable(cause_o) && $stable(next_pc_o) && $stable(badva_o));

    p_unknown_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_i && (kind_i > 5'd18) |=> $stable(epc_o) && $stable(cause_o) && $stable(next_pc_o));
endmodule

bind exc_entry_unit exc_entry_chk #(
    .BOOT_BASE (BOOT_BASE),
    .RUN_BASE  (RUN_BASE)
) u_exc_entry_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .kind_i    (kind_i),
    .pc_i      (pc_i),
    .delay_i   (delay_i),
    .exl_i     (exl_i),
    .bev_i     (bev_i),
    .epc_o     (epc_o),
    .cause_o   (cause_o),
    .exl_o     (exl_o),
    .badva_o   (badva_o),
    .next_pc_o (next_pc_o),
    .busy_q    (busy_q)
);

// File: tb/test_exc_entry_unit.sv
module test_exc_entry_unit;
    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [4:0]  kind_i = '0;
    logic [63:0] pc_i = '0;
    logic        delay_i = 1'b0;
    logic        exl_i = 1'b0;
    logic        bev_i = 1'b0;
    logic [63:0] bad_addr_i = '0;
    logic [63:0] epc_o;
    logic [31:0] cause_o;
    logic        exl_o;
    logic [63:0] badva_o;
    logic [63:0] next_pc_o;

    int checks = 0;
    int failures = 0;

    logic [63:0] m_epc = '0, m_bad = '0, m_npc = '0;
    logic        m_bd = 1'b0, m_exl = 1'b0, m_busy = 1'b0;
    logic [4:0]  m_code = '0;
    string       t_epc = "R11", t_vec = "R11", t_code = "R11", t_bad = "R11", t_exl = "R11";

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_unit i_exc_entry_unit (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .kind_i(kind_i), .pc_i(pc_i),
        .delay_i(delay_i), .exl_i(exl_i), .bev_i(bev_i), .bad_addr_i(bad_addr_i),
        .epc_o(epc_o), .cause_o(cause_o), .exl_o(exl_o), .badva_o(badva_o),
        .next_pc_o(next_pc_o)
    );

    function automatic logic [4:0] exp_code(input logic [4:0] k);
        case (k)
            5'd0: return 5'h00;   5'd1: return 5'h01;
            5'd2, 5'd14, 5'd16: return 5'h02;
            5'd3, 5'd15, 5'd17: return 5'h03;
            5'd4: return 5'h04;   5'd5: return 5'h05;
            5'd6: return 5'h08;   5'd7: return 5'h09;
            5'd8: return 5'h0A;   5'd9: return 5'h0B;
            5'd10: return 5'h0C;  5'd11: return 5'h0D;
            5'd12, 5'd13: return 5'h12;
            default: return 5'h18;
        endcase
    endfunction

    function automatic logic [63:0] exp_target(input logic [4:0] k, input logic exl, input logic bev);
        logic [63:0] ofs;
        if (exl) ofs = 64'h180;
        else if (k == 5'd14 || k == 5'd15) ofs = 64'h080;
        else if (k == 5'd13) ofs = 64'h280;
        else ofs = 64'h180;
        return (bev ? 64'hFFFFFFFFBFC00200 : 64'hFFFFFFFF80000000) + ofs;
    endfunction

    task automatic check64(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        check64(t_epc,  "epc",   epc_o, m_epc);
        check64(t_epc,  "bd",    {63'd0, cause_o[31]}, {63'd0, m_bd});
        check64(t_code, "code",  {59'd0, cause_o[6:2]}, {59'd0, m_code});
        check64("R6",   "cause", {32'd0, cause_o}, {32'd0, m_bd, 24'd0, m_code, 2'b00});
        check64(t_exl,  "exl",   {63'd0, exl_o}, {63'd0, m_exl});
        check64(t_bad,  "badva", badva_o, m_bad);
        check64(t_vec,  "npc",   next_pc_o, m_npc);
    endtask

    // drive one cycle of inputs (after checking the previous cycle) and update the model
    task automatic step(input logic req, input logic [4:0] k, input logic [63:0] pc,
                        input logic dly, input logic exl, input logic bev, input logic [63:0] bad);
        logic acc, known;
        @(negedge clk);
        check_all();
        req_i = req; kind_i = k; pc_i = pc; delay_i = dly;
        exl_i = exl; bev_i = bev; bad_addr_i = bad;
        known = (k <= 5'd18);
        acc = req && known && !m_busy;
        if (acc) begin
            t_exl = "R7"; t_code = "R5";
            t_vec = (exl || k == 5'd13 || k == 5'd14 || k == 5'd15) ? "R3" : "R4";
            if (!exl) begin
                t_epc = "R2";
                m_epc = dly ? pc - 64'd4 : pc;
                m_bd  = dly;
            end else begin
                t_epc = "R1";
            end
            m_code = exp_code(k);
            m_npc  = exp_target(k, exl, bev);
            t_bad  = "R8";
            if ((k >= 5'd1 && k <= 5'd5) || (k >= 5'd14 && k <= 5'd17)) m_bad = bad;
            m_exl  = 1'b1;
            m_busy = 1'b1;
        end else begin
            if (req && m_busy) begin
                t_epc = "R9"; t_vec = "R9"; t_code = "R9"; t_bad = "R9";
            end else if (req) begin
                t_epc = "R10"; t_vec = "R10"; t_code = "R10"; t_bad = "R10";
            end
            t_exl  = "R7";
            m_exl  = exl;
            m_busy = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] pcr, bdr;
        void'($urandom(32'd20240611));
        // R11: reset state
        repeat (2) @(negedge clk);
        check_all();
        rst_n = 1'b1;
        // directed corner cases
        step(1, 5'd6,  64'h0000_0000_0040_1000, 0, 0, 0, 64'h1);          // R2 plain, R4 base
        step(0, 5'd0,  64'h0, 0, 1, 0, 64'h0);                            // R7 follow
        step(1, 5'd4,  64'h0000_0000_0040_2004, 1, 0, 1, 64'hDEAD_BEEF);  // R2 slot, R8, bev
        step(0, 5'd0,  64'h0, 0, 0, 0, 64'h0);
        step(1, 5'd14, 64'h0000_0000_0000_0000, 1, 0, 0, 64'h1234_5678);  // R3 refill, pc wrap
        step(1, 5'd5,  64'h0000_0000_7777_0000, 0, 0, 0, 64'h9999);       // R9 dropped
        step(0, 5'd0,  64'h0, 0, 1, 1, 64'h0);
        step(1, 5'd16, 64'h0000_0000_0055_0000, 0, 1, 1, 64'hABCD);       // R1 nested, R3 nest vec
        step(0, 5'd0,  64'h0, 0, 0, 0, 64'h0);
        step(1, 5'd13, 64'h0000_0000_0066_0000, 0, 0, 0, 64'h0);          // R3 cp2 trap
        step(0, 5'd0,  64'h0, 0, 0, 0, 64'h0);
        step(1, 5'd25, 64'h0000_0000_0088_0000, 0, 0, 0, 64'hFFFF);       // R10 unknown kind
        step(1, 5'd18, 64'h0000_0000_0099_0000, 0, 0, 1, 64'h0);          // R5 mcheck
        // constrained random traffic
        for (int i = 0; i < N_RAND; i++) begin
            pcr = {$urandom, $urandom} & ~64'h3;
            bdr = {$urandom, $urandom};
            step(($urandom % 10) < 5,
                 (($urandom % 8) == 0) ? 5'(19 + $urandom % 13) : 5'($urandom % 19),
                 pcr, $urandom % 2, $urandom % 2, $urandom % 2, bdr);
        end
        @(negedge clk);
        check_all();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule